// File: doc/BRIEF.md
# Integer Arithmetic and Compare Unit with Checked and Wrapping Forms

This block is the integer execute stage for register-register and register-immediate instructions. It takes a 32-bit first operand and a second operand. The second operand is either a register value or a 16-bit immediate, widened to 32 bits by sign or zero extension. The unit computes one of six operations: add and subtract, each in a checked form and a wrapping form, and less-than compares with signed or unsigned ordering. The checked and wrapping forms produce the same result bits. Only the checked forms raise the overflow flag.

The result and the flag are held in a single output register. They appear one clock after the operands and the operation code are presented, and the unit accepts a new operation on every cycle. Subtraction always takes its second operand from the register input, because there is no immediate subtract. A negation is written as zero minus the register operand.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0 and `ovf_o` is 0.
- R2: The outputs change only at a rising clock edge and reflect the inputs present at that edge, so each result appears one cycle later. A new operation is accepted every cycle.
- R3: With `op_i` = 1 (wrapping add), `result_o` = (A + B) mod 2^32 and `ovf_o` = 0.
- R4: With `op_i` = 0 (checked add), `result_o` equals the wrapping add result. `ovf_o` = 1 exactly when A and B have the same sign bit and bit 31 of the result differs from that sign bit.
- R5: With `op_i` = 2 (checked subtract) or 3 (wrapping subtract), `result_o` = (`rs_i` − `rt_i`) mod 2^32. For code 2, `ovf_o` = 1 exactly when the operand sign bits differ and bit 31 of the result differs from bit 31 of `rs_i`. For code 3, `ovf_o` = 0.
- R6: For both subtract codes, B is always `rt_i`. The values of `bsrc_i` and `imm_i` have no effect.
- R7: With `op_i` = 4, `result_o` = 1 if A < B as two's-complement numbers, otherwise 0. Bits 31..1 are always 0 and `ovf_o` = 0.
- R8: With `op_i` = 5, `result_o` = 1 if A < B as unsigned numbers, otherwise 0. Bits 31..1 are always 0 and `ovf_o` = 0.
- R9: With `bsrc_i` = 1, B is `imm_i` with bit 15 copied into bits 31..16. This applies to the add and compare codes.
- R10: With `bsrc_i` = 2, B is `imm_i` with bits 31..16 cleared. With `bsrc_i` = 0 or 3, B is `rt_i`.
- R11: With `op_i` = 6 or 7, `result_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 checked add, 1 wrapping add, 2 checked sub, 3 wrapping sub, 4 signed less-than, 5 unsigned less-than) |
| bsrc_i | input | 2 | Second operand source (0/3 register, 1 sign-extended immediate, 2 zero-extended immediate) |
| rs_i | input | 32 | First operand A |
| rt_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The hardest cases to reach are the overflow boundaries. These are sums and differences that land exactly on the most positive or most negative value, and negating the most negative number, which random operands almost never hit. Directed vectors place operands at 0x7FFFFFFF, 0x80000000, 0 and −1 for both the checked and the wrapping forms.

The compares are driven with pairs whose signed and unsigned orderings disagree. Subtracts are issued with a nonzero immediate and an immediate source selected, so any leak of the immediate into the subtract path shows up in the result. A long run of random operands, random codes and random operand sources then follows back to back. An independent wide-integer model checks it on every cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_CHK  = 3'd0,
        OP_ADD_WRAP = 3'd1,
        OP_SUB_CHK  = 3'd2,
        OP_SUB_WRAP = 3'd3,
        OP_LT_S     = 3'd4,
        OP_LT_U     = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_SEXT = 2'd1,
        BSRC_ZEXT = 2'd2,
        BSRC_REG2 = 2'd3
    } bsrc_e;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] rt_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        bsrc_i,
    input  logic              force_reg_i,
    output logic [DATA_W-1:0] b_o
);
    import alu_pkg::*;

    localparam int FILL_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    generate
        if (FILL_W > 0) begin : g_widen
            assign imm_sext = {{FILL_W{imm_i[IMM_W-1]}}, imm_i};
            assign imm_zext = {{FILL_W{1'b0}}, imm_i};
        end else begin : g_narrow
            assign imm_sext = imm_i[DATA_W-1:0];
            assign imm_zext = imm_i[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        if (force_reg_i) begin
            b_o = rt_i;
        end else begin
            case (bsrc_e'(bsrc_i))
                BSRC_SEXT: b_o = imm_sext;
                BSRC_ZEXT: b_o = imm_zext;
                default:   b_o = rt_i;
            endcase
        end
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              checked_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
        sum_o = wide[MSB:0];
        ovf_o = checked_i && (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_i,
    output logic              lt_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] diff;
    logic            borrow;

    always_comb begin
        diff   = {1'b0, a_i} - {1'b0, b_i};
        borrow = diff[DATA_W];
        if (signed_i && (a_i[MSB] != b_i[MSB])) begin
            lt_o = a_i[MSB];
        end else begin
            lt_o = borrow;
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        bsrc_i,
    input  logic [DATA_W-1:0] rs_i,
    input  logic [DATA_W-1:0] rt_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o
);
    import alu_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              ovf;
    } out_t;

    out_t out_d, out_q;

    alu_op_e           op;
    logic              is_sub;
    logic              is_chk;
    logic [DATA_W-1:0] b_val;
    logic [DATA_W-1:0] arith;
    logic              arith_ovf;
    logic              lt;

    assign op     = alu_op_e'(op_i);
    assign is_sub = (op == OP_SUB_CHK) || (op == OP_SUB_WRAP);
    assign is_chk = (op == OP_ADD_CHK) || (op == OP_SUB_CHK);

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_opsel (
        .rt_i       (rt_i),
        .imm_i      (imm_i),
        .bsrc_i     (bsrc_i),
        .force_reg_i(is_sub),
        .b_o        (b_val)
    );

    alu_addsub #(.DATA_W(DATA_W)) i_addsub (
        .a_i      (rs_i),
        .b_i      (b_val),
        .sub_i    (is_sub),
        .checked_i(is_chk),
        .sum_o    (arith),
        .ovf_o    (arith_ovf)
    );

    alu_compare #(.DATA_W(DATA_W)) i_cmp (
        .a_i     (rs_i),
        .b_i     (b_val),
        .signed_i(op == OP_LT_S),
        .lt_o    (lt)
    );

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD_CHK, OP_ADD_WRAP, OP_SUB_CHK, OP_SUB_WRAP: begin
                out_d.result = arith;
                out_d.ovf    = arith_ovf;
            end
            OP_LT_S, OP_LT_U: begin
                out_d.result = {{(DATA_W-1){1'b0}}, lt};
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign ovf_o    = out_q.ovf;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> !ovf_o);

    a_r5_wrap_sub_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> !ovf_o);

    a_r4_mixed_sign_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && bsrc_i == 2'd0 && rs_i[DATA_W-1] != rt_i[DATA_W-1]) |=> !ovf_o);

    a_r7_compare_word: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 || op_i == 3'd5) |=> (result_o[DATA_W-1:1] == '0 && !ovf_o));

    a_r11_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 || op_i == 3'd7) |=> (result_o == '0 && !ovf_o));

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0 && !ovf_o));

endmodule

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  bsrc_i = '0;
    logic [31:0] rs_i = '0;
    logic [31:0] rt_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .bsrc_i(bsrc_i),
        .rs_i(rs_i), .rt_i(rt_i), .imm_i(imm_i),
        .result_o(result_o), .ovf_o(ovf_o)
    );

    function automatic logic [32:0] model(input logic [2:0] op, input logic [1:0] bs,
                                          input logic [31:0] a, input logic [31:0] r,
                                          input logic [15:0] im);
        longint sa, sb, s;
        logic [31:0] b;
        logic [31:0] res;
        logic        ov;
        if (op == 3'd2 || op == 3'd3) b = r;
        else if (bs == 2'd1) b = 32'(longint'($signed(im)));
        else if (bs == 2'd2) b = 32'(im);
        else b = r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        res = '0; ov = 1'b0;
        case (op)
            3'd0, 3'd1: begin
                s = sa + sb;
                res = 32'(s);
                ov = (op == 3'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            3'd2, 3'd3: begin
                s = sa - sb;
                res = 32'(s);
                ov = (op == 3'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            3'd4: res = (sa < sb) ? 32'd1 : 32'd0;
            3'd5: res = (a < b) ? 32'd1 : 32'd0;
            default: res = '0;
        endcase
        return {ov, res};
    endfunction

    task automatic step(input string tag, input logic [2:0] op, input logic [1:0] bs,
                        input logic [31:0] a, input logic [31:0] r, input logic [15:0] im);
        logic [32:0] exp;
        op_i = op; bsrc_i = bs; rs_i = a; rt_i = r; imm_i = im;
        exp = model(op, bs, a, r, im);
        @(negedge clk);
        checks++;
        if ({ovf_o, result_o} !== exp) begin
            fails++;
            $display("FAIL %s: op=%0d bsrc=%0d a=%h b=%h imm=%h got res=%h ovf=%b exp res=%h ovf=%b",
                     tag, op, bs, a, r, im, result_o, ovf_o, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        op_i = 3'd1; rs_i = 32'h1234_5678; rt_i = 32'h1111_1111;
        repeat (3) @(negedge clk);
        checks++; // R1
        if (result_o !== 32'd0 || ovf_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: got res=%h ovf=%b exp res=0 ovf=0", result_o, ovf_o);
        end
        rst_n = 1'b1;

        step("R3", 3'd1, 2'd0, 32'h7fff_ffff, 32'h1, 16'h0);
        step("R4", 3'd0, 2'd0, 32'h7fff_ffff, 32'h1, 16'h0);
        step("R4", 3'd0, 2'd0, 32'h8000_0000, 32'h8000_0000, 16'h0);
        step("R3", 3'd1, 2'd0, 32'h8000_0000, 32'h8000_0000, 16'h0);
        step("R4", 3'd0, 2'd0, 32'h7fff_ffff, 32'hffff_ffff, 16'h0);
        step("R5", 3'd2, 2'd0, 32'h8000_0000, 32'h1, 16'h0);
        step("R5", 3'd3, 2'd0, 32'h8000_0000, 32'h1, 16'h0);
        step("R5", 3'd2, 2'd0, 32'h0, 32'h8000_0000, 16'h0);
        step("R5", 3'd2, 2'd0, 32'h0, 32'h5, 16'h0);
        step("R5", 3'd2, 2'd0, 32'h7fff_ffff, 32'hffff_ffff, 16'h0);
        step("R6", 3'd2, 2'd1, 32'd10, 32'd3, 16'hffff);
        step("R6", 3'd3, 2'd2, 32'd10, 32'd3, 16'h1234);
        step("R7", 3'd4, 2'd0, 32'hffff_ffff, 32'h1, 16'h0);
        step("R7", 3'd4, 2'd0, 32'h5, 32'h5, 16'h0);
        step("R7", 3'd4, 2'd0, 32'h7fff_ffff, 32'h8000_0000, 16'h0);
        step("R8", 3'd5, 2'd0, 32'hffff_ffff, 32'h1, 16'h0);
        step("R8", 3'd5, 2'd0, 32'h1, 32'hffff_ffff, 16'h0);
        step("R9", 3'd1, 2'd1, 32'h0, 32'h0, 16'h8000);
        step("R10", 3'd1, 2'd2, 32'h0, 32'h0, 16'h8000);
        step("R9", 3'd4, 2'd1, 32'h0, 32'h0, 16'hffff);
        step("R9", 3'd5, 2'd1, 32'h5, 32'h0, 16'hffff);
        step("R10", 3'd5, 2'd2, 32'h5, 32'h0, 16'hffff);
        step("R10", 3'd1, 2'd3, 32'd3, 32'd2, 16'hffff);
        step("R11", 3'd6, 2'd0, 32'hffff_ffff, 32'hffff_ffff, 16'hffff);
        step("R11", 3'd7, 2'd1, 32'h8000_0000, 32'h8000_0000, 16'h8000);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, r;
            a = $urandom; r = $urandom;
            if (i % 7 == 0) a = {a[31], 31'h7fff_ffff};
            step("R2", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), a, r, 16'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule